// File: doc/BRIEF.md
# Symbol Intrinsic Candidate Generator

This block takes the soft channel information for one GF(2^m) symbol, with one signed log-likelihood value per bit, and turns it into a short ranked list of likely symbol values. There are four (LLR, symbol) candidates in non-decreasing LLR order. The block also emits a compact pre-processed record. That record holds the per-bit magnitudes, the positions of the three weakest bits and the hard-decision symbol, so a later stage can rebuild the cost of any symbol.

The candidates come straight from the three smallest bit magnitudes by fixed bit-flip rules. The block never enumerates or sorts all symbol values. It is a two-stage pipeline with a valid strobe on each side and no stall path. Scaling and quantization of the channel values happen before this block. Storage of the results happens after it.

Top module: `sym_cand_gen`

## Requirements
- R1: Bit p of the hard symbol is 1 when LLR p is zero or negative, and 0 when it is strictly positive. Candidate 0 is the hard symbol, and its LLR is 0 and not carried.
- R2: pre_o bits [5p+4:5p] hold |LLR p| for p = 0..5.
- R3: pre_o bits [30+3r+2:30+3r] hold the bit index of the r-th smallest magnitude, for r = 0, 1, 2. Equal magnitudes rank the lower bit index first. pre_o bits [44:39] hold the hard symbol.
- R4: Candidate 1 is the hard symbol with the bit at index r0 inverted, and its LLR is that bit's magnitude. Candidate 2 does the same for index r1.
- R5: For candidate 3, let A be the sum of the two smallest magnitudes and B the third smallest. If A <= B, both of those bits are inverted and the LLR is A. Otherwise only bit r2 is inverted and the LLR is B. A saturates at 63.
- R6: cand_o carries symbol k (k = 0..3) in bits [6k+5:6k] and the LLR of candidate k (k = 1..3) in bits [24+6(k-1)+5:24+6(k-1)].
- R7: valid_o is high exactly two clock cycles after valid_i is high. Reset clears valid_o, cand_o and pre_o to 0.
- R8: While valid_i is low, a result already issued stays on cand_o and pre_o unchanged.
- R9: The four candidates are four distinct symbols whose costs are the four smallest among all 64 symbols. The cost of a symbol is the sum of the magnitudes of the bits where it differs from the hard symbol. The candidate LLRs are non-decreasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input LLR vector is valid |
| llr_i | input | 36 | Six signed 6-bit bit LLRs, bit p at [6p+5:6p] |
| valid_o | output | 1 | Outputs carry a new result |
| cand_o | output | 42 | Four candidate symbols and three non-zero LLRs |
| pre_o | output | 45 | Magnitudes, three weakest-bit indices, hard symbol |

## Verification
The bench builds the block with its default parameters: six bits per symbol and 6-bit LLRs. With these values a field of only 64 symbols can be enumerated in full. Every result can therefore be compared against an exhaustive cost ranking, in addition to the exact flip-rule model. The 5-bit magnitudes keep ties easy to force. This brings within reach the tie orderings between equal magnitudes, the A = B boundary and the zero-LLR hard decision.

// File: rtl/sym_cand_pkg.sv
package sym_cand_pkg;
  localparam int CAND_N = 4;  // candidates per symbol
  localparam int RANK_N = 3;  // weakest bits tracked
endpackage

// File: rtl/sym_mag_unit.sv
module sym_mag_unit #(
  parameter int BITS_P = 6,
  parameter int LLR_W  = 6,
  localparam int MAG_W = LLR_W - 1
) (
  input  logic [BITS_P*LLR_W-1:0] llr_i,
  output logic [BITS_P*MAG_W-1:0] mag_o,
  output logic [BITS_P-1:0]       hard_o
);
  for (genvar p = 0; p < BITS_P; p++) begin : g_bit
    logic signed [LLR_W-1:0] v;
    logic        [LLR_W-1:0] neg;
    assign v   = llr_i[p*LLR_W +: LLR_W];
    assign neg = (~v) + LLR_W'(1);
    assign hard_o[p] = !(v > 0);
    always_comb begin
      if (!v[LLR_W-1])       mag_o[p*MAG_W +: MAG_W] = v[MAG_W-1:0];
      else if (neg[MAG_W])   mag_o[p*MAG_W +: MAG_W] = '1;  // most negative code
      else                   mag_o[p*MAG_W +: MAG_W] = neg[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/sym_rank3.sv
module sym_rank3
  import sym_cand_pkg::*;
#(
  parameter int BITS_P = 6,
  parameter int MAG_W  = 5,
  localparam int IDX_W = $clog2(BITS_P)
) (
  input  logic [BITS_P*MAG_W-1:0] mag_i,
  output logic [RANK_N*IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rank [BITS_P];

  // rank = number of bits that beat this one (lower index wins ties)
  for (genvar i = 0; i < BITS_P; i++) begin : g_rank
    always_comb begin
      rank[i] = '0;
      for (int j = 0; j < BITS_P; j++) begin
        if (j != i) begin
          if ((mag_i[j*MAG_W +: MAG_W] < mag_i[i*MAG_W +: MAG_W]) ||
              ((mag_i[j*MAG_W +: MAG_W] == mag_i[i*MAG_W +: MAG_W]) && (j < i)))
            rank[i] = rank[i] + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < BITS_P; i++)
      for (int r = 0; r < RANK_N; r++)
        if (rank[i] == IDX_W'(r)) idx_o[r*IDX_W +: IDX_W] = IDX_W'(i);
  end
endmodule

// File: rtl/sym_cand_build.sv
module sym_cand_build
  import sym_cand_pkg::*;
#(
  parameter int BITS_P = 6,
  parameter int LLR_W  = 6,
  localparam int MAG_W  = LLR_W - 1,
  localparam int IDX_W  = $clog2(BITS_P),
  localparam int CAND_W = CAND_N*BITS_P + (CAND_N-1)*LLR_W
) (
  input  logic [BITS_P-1:0]       hard_i,
  input  logic [BITS_P*MAG_W-1:0] mag_i,
  input  logic [RANK_N*IDX_W-1:0] idx_i,
  output logic [CAND_W-1:0]       cand_o
);
  localparam int SYM_BASE = CAND_N*BITS_P;

  logic [IDX_W-1:0]  ix0, ix1, ix2;
  logic [MAG_W-1:0]  m0, m1, m2;
  logic [LLR_W:0]    sum_a;
  logic [LLR_W-1:0]  a_sat, b_ext;
  logic [BITS_P-1:0] f0, f1, f2;

  assign ix0 = idx_i[0*IDX_W +: IDX_W];
  assign ix1 = idx_i[1*IDX_W +: IDX_W];
  assign ix2 = idx_i[2*IDX_W +: IDX_W];
  assign m0  = mag_i[ix0*MAG_W +: MAG_W];
  assign m1  = mag_i[ix1*MAG_W +: MAG_W];
  assign m2  = mag_i[ix2*MAG_W +: MAG_W];
  assign f0  = BITS_P'(1) << ix0;
  assign f1  = BITS_P'(1) << ix1;
  assign f2  = BITS_P'(1) << ix2;

  assign sum_a = (LLR_W+1)'(m0) + (LLR_W+1)'(m1);
  assign a_sat = sum_a[LLR_W] ? '1 : sum_a[LLR_W-1:0];
  assign b_ext = LLR_W'(m2);

  always_comb begin
    cand_o = '0;
    cand_o[0*BITS_P +: BITS_P] = hard_i;
    cand_o[1*BITS_P +: BITS_P] = hard_i ^ f0;
    cand_o[2*BITS_P +: BITS_P] = hard_i ^ f1;
    cand_o[SYM_BASE + 0*LLR_W +: LLR_W] = LLR_W'(m0);
    cand_o[SYM_BASE + 1*LLR_W +: LLR_W] = LLR_W'(m1);
    if (a_sat <= b_ext) begin
      cand_o[3*BITS_P +: BITS_P]          = hard_i ^ f0 ^ f1;
      cand_o[SYM_BASE + 2*LLR_W +: LLR_W] = a_sat;
    end else begin
      cand_o[3*BITS_P +: BITS_P]          = hard_i ^ f2;
      cand_o[SYM_BASE + 2*LLR_W +: LLR_W] = b_ext;
    end
  end
endmodule

// File: rtl/sym_cand_gen.sv
module sym_cand_gen
  import sym_cand_pkg::*;
#(
  parameter int BITS_P = 6,
  parameter int LLR_W  = 6,
  localparam int MAG_W  = LLR_W - 1,
  localparam int IDX_W  = $clog2(BITS_P),
  localparam int CAND_W = CAND_N*BITS_P + (CAND_N-1)*LLR_W,
  localparam int PRE_W  = BITS_P*MAG_W + RANK_N*IDX_W + BITS_P
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [BITS_P*LLR_W-1:0] llr_i,
  output logic                    valid_o,
  output logic [CAND_W-1:0]       cand_o,
  output logic [PRE_W-1:0]        pre_o
);
  logic [BITS_P*MAG_W-1:0] mag_c, mag_q;
  logic [BITS_P-1:0]       hard_c, hard_q;
  logic [RANK_N*IDX_W-1:0] idx_c, idx_q;
  logic                    v_q;
  logic [CAND_W-1:0]       cand_c;

  sym_mag_unit #(.BITS_P(BITS_P), .LLR_W(LLR_W)) u_mag (
    .llr_i (llr_i), .mag_o (mag_c), .hard_o (hard_c));

  sym_rank3 #(.BITS_P(BITS_P), .MAG_W(MAG_W)) u_rank (
    .mag_i (mag_c), .idx_o (idx_c));

  // stage 1: magnitudes, hard symbol, weakest-bit indices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; mag_q <= '0; hard_q <= '0; idx_q <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        mag_q <= mag_c; hard_q <= hard_c; idx_q <= idx_c;
      end
    end
  end

  sym_cand_build #(.BITS_P(BITS_P), .LLR_W(LLR_W)) u_build (
    .hard_i (hard_q), .mag_i (mag_q), .idx_i (idx_q), .cand_o (cand_c));

  // stage 2: candidate list and pre-processed record
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; cand_o <= '0; pre_o <= '0;
    end else begin
      valid_o <= v_q;
      if (v_q) begin
        cand_o <= cand_c;
        pre_o  <= {hard_q, idx_q, mag_q};
      end
    end
  end
endmodule

// File: rtl/sym_cand_gen_chk.sv
module sym_cand_gen_chk #(
  parameter int BITS_P = 6,
  parameter int LLR_W  = 6,
  localparam int MAG_W  = LLR_W - 1,
  localparam int IDX_W  = $clog2(BITS_P),
  localparam int CAND_W = 4*BITS_P + 3*LLR_W,
  localparam int PRE_W  = BITS_P*MAG_W + 3*IDX_W + BITS_P
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              valid_o,
  input logic [CAND_W-1:0] cand_o,
  input logic [PRE_W-1:0]  pre_o
);
  localparam int IB = BITS_P*MAG_W;
  logic seen;
  logic [BITS_P-1:0] s0, s1, s2, s3, hard;
  logic [LLR_W-1:0]  l1, l2, l3;
  logic [IDX_W-1:0]  i0, i1, i2;

  assign s0 = cand_o[0*BITS_P +: BITS_P];
  assign s1 = cand_o[1*BITS_P +: BITS_P];
  assign s2 = cand_o[2*BITS_P +: BITS_P];
  assign s3 = cand_o[3*BITS_P +: BITS_P];
  assign l1 = cand_o[4*BITS_P + 0*LLR_W +: LLR_W];
  assign l2 = cand_o[4*BITS_P + 1*LLR_W +: LLR_W];
  assign l3 = cand_o[4*BITS_P + 2*LLR_W +: LLR_W];
  assign i0 = pre_o[IB + 0*IDX_W +: IDX_W];
  assign i1 = pre_o[IB + 1*IDX_W +: IDX_W];
  assign i2 = pre_o[IB + 2*IDX_W +: IDX_W];
  assign hard = pre_o[IB + 3*IDX_W +: BITS_P];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen <= 1'b0; else seen <= 1'b1;

  p_cand0_hard_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> s0 == hard);
  p_idx_distinct_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (i0 != i1) && (i1 != i2) && (i0 != i2) &&
                (i0 < BITS_P) && (i1 < BITS_P) && (i2 < BITS_P));
  p_single_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(s1 ^ s0) == 1) && ($countones(s2 ^ s0) == 1));
  p_fourth_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(s3 ^ s0) == 1) || ($countones(s3 ^ s0) == 2));
  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !valid_o) |-> ($stable(cand_o) && $stable(pre_o)));
  p_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (l1 <= l2) && (l2 <= l3));
endmodule

bind sym_cand_gen sym_cand_gen_chk #(.BITS_P(BITS_P), .LLR_W(LLR_W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i),
  .valid_o (valid_o), .cand_o (cand_o), .pre_o (pre_o));

// File: tb/sim_sym_cand_gen.sv
module sim_sym_cand_gen;
  localparam int B = 6, W = 6, M = 5;

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [35:0] llr_i = '0;
  logic        valid_o;
  logic [41:0] cand_o;
  logic [44:0] pre_o;
  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  sym_cand_gen u0 (.clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
                   .llr_i(llr_i), .valid_o(valid_o), .cand_o(cand_o), .pre_o(pre_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] pack(input int v0, v1, v2, v3, v4, v5);
    int v[6] = '{v0, v1, v2, v3, v4, v5};
    logic [35:0] r = '0;
    for (int p = 0; p < 6; p++) r[p*W +: W] = 6'(v[p]);
    return r;
  endfunction

  // flip-rule model written from R1..R6
  task automatic model(input logic [35:0] v, output logic [41:0] c, output logic [44:0] pr);
    int mg[6]; int ix[3]; bit used[6]; logic [5:0] h; int a, bb;
    h = '0;
    for (int p = 0; p < 6; p++) begin
      int s = $signed(v[p*W +: W]);
      h[p] = (s <= 0);
      mg[p] = (s < 0) ? ((-s > 31) ? 31 : -s) : s;
      used[p] = 0;
    end
    for (int r = 0; r < 3; r++) begin
      int best = -1;
      for (int p = 0; p < 6; p++)
        if (!used[p] && (best < 0 || mg[p] < mg[best])) best = p;
      ix[r] = best; used[best] = 1;
    end
    a = mg[ix[0]] + mg[ix[1]]; if (a > 63) a = 63;
    bb = mg[ix[2]];
    c = '0;
    c[5:0]   = h;
    c[11:6]  = h ^ (6'd1 << ix[0]);
    c[17:12] = h ^ (6'd1 << ix[1]);
    c[29:24] = 6'(mg[ix[0]]);
    c[35:30] = 6'(mg[ix[1]]);
    if (a <= bb) begin c[23:18] = h ^ (6'd1 << ix[0]) ^ (6'd1 << ix[1]); c[41:36] = 6'(a); end
    else         begin c[23:18] = h ^ (6'd1 << ix[2]);                   c[41:36] = 6'(bb); end
    pr = '0;
    for (int p = 0; p < 6; p++) pr[p*M +: M] = 5'(mg[p]);
    for (int r = 0; r < 3; r++) pr[30+3*r +: 3] = 3'(ix[r]);
    pr[44:39] = h;
  endtask

  task automatic run_vec(input logic [35:0] v);
    @(negedge clk_i); valid_i = 1'b1; llr_i = v;
    @(negedge clk_i); valid_i = 1'b0; llr_i = '0;
    @(posedge clk_i); #1;
  endtask

  // R9: exhaustive cost ranking over all 64 symbols
  task automatic check_rank(input string tag);
    int cost[64]; logic [5:0] h; int lk[4]; logic [5:0] sk[4]; bit ok = 1;
    h = pre_o[44:39];
    for (int s = 0; s < 64; s++) begin
      cost[s] = 0;
      for (int p = 0; p < 6; p++) if ((6'(s) ^ h) & (6'd1 << p)) cost[s] += int'(pre_o[p*M +: M]);
    end
    lk[0] = 0;
    for (int k = 0; k < 4; k++) sk[k] = cand_o[k*6 +: 6];
    for (int k = 1; k < 4; k++) lk[k] = int'(cand_o[24+(k-1)*6 +: 6]);
    for (int k = 0; k < 4; k++) begin
      int below = 0;
      if (cost[sk[k]] != lk[k]) ok = 0;
      if (k > 0 && lk[k] < lk[k-1]) ok = 0;
      for (int j = 0; j < k; j++) if (sk[j] == sk[k]) ok = 0;
      for (int s = 0; s < 64; s++) if (cost[s] < lk[k]) below++;
      if (below > k) ok = 0;
    end
    chk(ok, {"R9 ", tag}, 64'(cand_o), 64'(cand_o));
  endtask

  task automatic check_vec(input logic [35:0] v, input string tag);
    logic [41:0] ec; logic [44:0] ep;
    model(v, ec, ep);
    run_vec(v);
    chk(valid_o == 1'b1, {"R7 ", tag}, 64'(valid_o), 64'd1);
    chk(cand_o[5:0] == ec[5:0], {"R1 ", tag}, 64'(cand_o[5:0]), 64'(ec[5:0]));
    chk(pre_o[29:0] == ep[29:0], {"R2 ", tag}, 64'(pre_o[29:0]), 64'(ep[29:0]));
    chk(pre_o[44:30] == ep[44:30], {"R3 ", tag}, 64'(pre_o[44:30]), 64'(ep[44:30]));
    chk({cand_o[35:24], cand_o[17:6]} == {ec[35:24], ec[17:6]}, {"R4 ", tag},
        64'({cand_o[35:24], cand_o[17:6]}), 64'({ec[35:24], ec[17:6]}));
    chk({cand_o[41:36], cand_o[23:18]} == {ec[41:36], ec[23:18]}, {"R5 R6 ", tag},
        64'({cand_o[41:36], cand_o[23:18]}), 64'({ec[41:36], ec[23:18]}));
    check_rank(tag);
  endtask

  task automatic t_reset;
    chk(valid_o == 1'b0 && cand_o == '0 && pre_o == '0, "R7 reset", 64'(valid_o), 64'd0);
  endtask

  task automatic t_hard_zero;  // R1: zero LLR decides 1
    check_vec(pack(0, 5, -3, 0, 9, -1), "zero llr");
    chk(cand_o[5:0] == 6'b101101, "R1 hard", 64'(cand_o[5:0]), 64'b101101);
  endtask

  task automatic t_fourth_modes;  // R5
    check_vec(pack(2, -3, 20, 20, 20, 30), "A<B");
    chk(cand_o[41:36] == 6'd5, "R5 A<B llr", 64'(cand_o[41:36]), 64'd5);
    check_vec(pack(4, -5, 9, 20, 20, 30), "A=B");
    chk(cand_o[41:36] == 6'd9 && cand_o[23:18] == (cand_o[5:0] ^ 6'b000011),
        "R5 A=B picks A", 64'(cand_o[23:18]), 64'(cand_o[5:0] ^ 6'b000011));
    check_vec(pack(4, -6, 7, 20, 20, 30), "A>B");
    chk(cand_o[41:36] == 6'd7, "R5 A>B llr", 64'(cand_o[41:36]), 64'd7);
  endtask

  task automatic t_ties;  // R3
    check_vec(pack(7, 7, 7, 7, 7, 7), "all equal");
    chk(pre_o[38:30] == {3'd2, 3'd1, 3'd0}, "R3 tie order", 64'(pre_o[38:30]), 64'({3'd2, 3'd1, 3'd0}));
    check_vec(pack(31, -31, 1, -1, 31, 1), "pair ties");
    chk(pre_o[38:30] == {3'd5, 3'd3, 3'd2}, "R3 tie order b", 64'(pre_o[38:30]), 64'({3'd5, 3'd3, 3'd2}));
    check_vec(pack(31, 31, 31, 31, 31, 31), "max mag");
    check_vec(pack(-31, -31, -31, -31, -31, -31), "min mag");
  endtask

  task automatic t_latency_hold;  // R7, R8
    logic [41:0] c0; logic [44:0] p0;
    @(negedge clk_i); valid_i = 1'b1; llr_i = pack(3, -8, 12, 1, -4, 6);
    @(negedge clk_i); valid_i = 1'b0; llr_i = pack(-9, 9, -9, 9, -9, 9);
    chk(valid_o == 1'b0, "R7 not early", 64'(valid_o), 64'd0);
    @(negedge clk_i);
    chk(valid_o == 1'b1, "R7 two cycles", 64'(valid_o), 64'd1);
    c0 = cand_o; p0 = pre_o;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0 && cand_o == c0 && pre_o == p0, "R8 hold", 64'(cand_o), 64'(c0));
  endtask

  task automatic t_random;  // R9 over random vectors
    for (int n = 0; n < 300; n++) begin
      int v[6];
      for (int p = 0; p < 6; p++) v[p] = int'($urandom_range(62)) - 31;
      check_vec(pack(v[0], v[1], v[2], v[3], v[4], v[5]), "random");
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_hard_zero();
    t_fourth_modes();
    t_ties();
    t_latency_hold();
    t_random();
    finish_run();
  end
endmodule